// File: doc/BRIEF.md
# Longest Prefix Match Route Lookup

This block holds a small table of IPv4 routes. Each route has a prefix value, a prefix length and an outgoing port. A 32-bit destination address is presented on a request stream. The block compares that address against every stored route at the same time, keeping only the routes whose leading bits agree with the address over their own length. Of those routes, it picks the one with the longest prefix, which is the most specific route. The result stream then carries a hit flag and the winning route's port. When nothing matches, the hit flag is low and the port is zero.

Software or a control engine fills the table through a plain write port. Each write gives an entry index, a prefix, a length, a port and a valid bit. A write lands at the clock edge. Lookups accepted in any later cycle see the new contents. A lookup accepted in the same cycle as the write still sees the old contents.

Both streams use valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A result is delivered on a cycle where `res_valid` and `res_ready` are both high. The whole pipeline advances as one unit. While a result is waiting with `res_ready` low, the pipeline freezes: `req_ready` goes low, the waiting result stays unchanged, and no request is accepted or lost. With `res_ready` held high, the block accepts one lookup per cycle. Each result appears a fixed 1 + log2(N_ENTRIES) cycles after its request, which is 4 cycles for the default of 8 entries. Results come out in the order the requests were accepted.

Top module: `lpm_lookup`

## Requirements
- R1: An entry matches an address when its valid bit is set, its length L is in the range 1 to 32, and the top L bits of the address equal the top L bits of the stored prefix. An entry with length 0, or with a length above 32, never matches.
- R2: When several entries match, the result port is the port of the matching entry with the greatest length, wherever that entry sits in the table. For example, with 128.9.0.0/16 and 128.9.16.0/21 loaded, the address 128.9.16.14 returns the /21 port.
- R3: When two matching entries have the same greatest length, the entry with the lower index wins.
- R4: When no entry matches, `res_hit` is 0 and `res_port` is 0. When an entry matches, `res_hit` is 1.
- R5: With `res_ready` held high, the block accepts one request per cycle. Each result has `res_valid` high exactly 1 + log2(N_ENTRIES) cycles after the edge that accepted its request, which is 4 cycles at the defaults. At most that many lookups are in flight at once.
- R6: While `res_valid` is 1 and `res_ready` is 0, `req_ready` is 0. On the next cycle `res_valid` stays 1 and `res_hit` and `res_port` keep their values. No result is dropped or reordered.
- R7: A table write at an edge changes the result of every lookup accepted at a later edge. A lookup accepted at the same edge as the write uses the table contents from before the write.
- R8: After reset the table is empty, `res_valid` is 0 and `req_ready` is 1. A lookup made before any write returns a miss.
- R9: A write with `wr_valid` at 0 removes the entry at that index, so lookups accepted afterwards fall back to the remaining routes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | log2(N_ENTRIES) | Index of the entry being written |
| wr_prefix | input | 32 | Prefix value; bit 31 is the first prefix bit |
| wr_len | input | 6 | Prefix length in bits (1 to 32 can match) |
| wr_port | input | PORT_W | Outgoing port for the route |
| wr_valid | input | 1 | 1 to install the entry, 0 to remove it |
| req_valid | input | 1 | A lookup request is offered |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_addr | input | 32 | Destination address to look up |
| res_valid | output | 1 | A lookup result is offered |
| res_ready | input | 1 | The consumer takes the result this cycle |
| res_hit | output | 1 | At least one route matched |
| res_port | output | PORT_W | Port of the winning route, 0 on a miss |

## Verification
Two functions can fall in the same cycle: a table write and the acceptance of a lookup. The bench drives both together, in directed cycles and many times during random traffic. Its reference model computes the expected result from the table as it was before the write, then applies the write, so a lookup that sees the new entry too early is caught. The second overlap is back-pressure arriving while a new request is offered. Random `res_ready` gaps provoke it, and the bench checks that the waiting result stays still and that the offered request is refused until the stall clears.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  plen_t;

  // bit b of the mask is set when it lies within the leading len bits
  function automatic addr_t prefix_mask(input plen_t len);
    addr_t m;
    for (int b = 0; b < ADDR_W; b++) begin
      m[b] = ((b + int'(len)) >= ADDR_W);
    end
    return m;
  endfunction

  function automatic logic len_usable(input plen_t len);
    return (len != '0) && (int'(len) <= ADDR_W);
  endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  addr_t                          wr_prefix,
  input  plen_t                          wr_len,
  input  logic [PORT_W-1:0]              wr_port,
  input  logic                           wr_valid,
  output logic [N_ENTRIES-1:0]           tbl_valid,
  output addr_t [N_ENTRIES-1:0]          tbl_prefix,
  output plen_t [N_ENTRIES-1:0]          tbl_len,
  output logic [N_ENTRIES-1:0][PORT_W-1:0] tbl_port
);
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_valid[e]  <= 1'b0;
        tbl_prefix[e] <= '0;
        tbl_len[e]    <= '0;
        tbl_port[e]   <= '0;
      end else if (sel) begin
        tbl_valid[e]  <= wr_valid;
        tbl_prefix[e] <= wr_prefix;
        tbl_len[e]    <= wr_len;
        tbl_port[e]   <= wr_port;
      end
    end
  end
endmodule

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  addr_t                 addr,
  input  logic [N_ENTRIES-1:0]  tbl_valid,
  input  addr_t [N_ENTRIES-1:0] tbl_prefix,
  input  plen_t [N_ENTRIES-1:0] tbl_len,
  output logic [N_ENTRIES-1:0]  hit
);
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    addr_t diff;
    assign diff   = (addr ^ tbl_prefix[e]) & prefix_mask(tbl_len[e]);
    assign hit[e] = tbl_valid[e] && len_usable(tbl_len[e]) && (diff == '0);
  end
endmodule

// File: rtl/lpm_reduce.sv
module lpm_reduce
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int LEVELS   = $clog2(N_ENTRIES),
  localparam int N_PAD    = 1 << LEVELS,
  localparam int NODES    = 2 * N_PAD - 1,
  localparam int LEAF0    = N_PAD - 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             adv,
  input  logic [N_ENTRIES-1:0]             hit,
  input  plen_t [N_ENTRIES-1:0]            len,
  input  logic [N_ENTRIES-1:0][PORT_W-1:0] port,
  output logic                             win_vld,
  output logic [PORT_W-1:0]                win_port
);
  // heap-ordered tree: node i has children 2i+1 (lower indices) and 2i+2
  logic              n_vld  [NODES];
  plen_t             n_len  [NODES];
  logic [PORT_W-1:0] n_port [NODES];
  logic              x_vld  [NODES];
  plen_t             x_len  [NODES];
  logic [PORT_W-1:0] x_port [NODES];

  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      x_vld[i]  = 1'b0;
      x_len[i]  = '0;
      x_port[i] = '0;
      if (i >= LEAF0) begin
        if (i - LEAF0 < N_ENTRIES) begin
          x_vld[i] = hit[i-LEAF0];
          if (hit[i-LEAF0]) begin
            x_len[i]  = len[i-LEAF0];
            x_port[i] = port[i-LEAF0];
          end
        end
      end else begin
        // the right child wins only when strictly longer: ties go to the lower index
        if (n_vld[2*i+2] && (!n_vld[2*i+1] || (n_len[2*i+2] > n_len[2*i+1]))) begin
          x_vld[i]  = 1'b1;
          x_len[i]  = n_len[2*i+2];
          x_port[i] = n_port[2*i+2];
        end else begin
          x_vld[i]  = n_vld[2*i+1];
          x_len[i]  = n_len[2*i+1];
          x_port[i] = n_port[2*i+1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin
        n_vld[i]  <= 1'b0;
        n_len[i]  <= '0;
        n_port[i] <= '0;
      end
    end else if (adv) begin
      for (int i = 0; i < NODES; i++) begin
        n_vld[i]  <= x_vld[i];
        n_len[i]  <= x_len[i];
        n_port[i] <= x_port[i];
      end
    end
  end

  assign win_vld  = n_vld[0];
  assign win_port = n_port[0];
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int LAT      = $clog2(N_ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_prefix,
  input  logic [5:0]        wr_len,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              wr_valid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port
);
  logic [N_ENTRIES-1:0]             t_valid;
  addr_t [N_ENTRIES-1:0]            t_prefix;
  plen_t [N_ENTRIES-1:0]            t_len;
  logic [N_ENTRIES-1:0][PORT_W-1:0] t_port;
  logic [N_ENTRIES-1:0]             m_hit;
  logic [LAT-1:0]                   stage_vld;
  logic                             adv;

  // the pipeline moves as one unit unless a result is waiting unconsumed
  assign adv       = !res_valid || res_ready;
  assign req_ready = adv;

  lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port), .wr_valid(wr_valid),
    .tbl_valid(t_valid), .tbl_prefix(t_prefix), .tbl_len(t_len), .tbl_port(t_port)
  );

  lpm_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr(req_addr), .tbl_valid(t_valid), .tbl_prefix(t_prefix), .tbl_len(t_len),
    .hit(m_hit)
  );

  lpm_reduce #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_reduce (
    .clk(clk), .rst_n(rst_n), .adv(adv), .hit(m_hit), .len(t_len), .port(t_port),
    .win_vld(res_hit), .win_port(res_port)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_vld <= '0;
    end else if (adv) begin
      stage_vld <= {stage_vld[LAT-2:0], req_valid};
    end
  end

  assign res_valid = stage_vld[LAT-1];
endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
  parameter int PORT_W = 4,
  parameter int LAT    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic [PORT_W-1:0] res_port
);
  logic [7:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(req_valid && req_ready) - 8'(res_valid && res_ready);
  end

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_port == '0);

  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_port));

  p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inflight) <= LAT);

  p_reset_idle_r8: assert property (@(posedge clk)
    !rst_n |=> !res_valid);
endmodule

bind lpm_lookup lpm_lookup_chk #(.PORT_W(PORT_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_port(res_port)
);

// File: tb/lpm_lookup_tb.sv
module lpm_lookup_tb;
  localparam int N   = 8;
  localparam int PW  = 4;
  localparam int IW  = 3;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_prefix = '0;
  logic [5:0]    wr_len = '0;
  logic [PW-1:0] wr_port = '0;
  logic          wr_valid = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_hit;
  logic [PW-1:0] res_port;

  always #10 clk = ~clk;

  lpm_lookup #(.N_ENTRIES(N), .PORT_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_prefix(wr_prefix),
    .wr_len(wr_len), .wr_port(wr_port), .wr_valid(wr_valid), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_port(res_port)
  );

  // reference table
  logic          m_v    [N];
  logic [31:0]   m_pfx  [N];
  logic [5:0]    m_len  [N];
  logic [PW-1:0] m_port [N];

  bit            qh [$];
  logic [PW-1:0] qp [$];
  string         qt [$];
  int            qs [$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit lat_mode = 0;
  bit prev_stall = 0;
  logic          held_hit;
  logic [PW-1:0] held_port;

  function automatic logic [31:0] ref_mask(input int len);
    if (len == 0) return 32'h0;
    return ~(32'hFFFF_FFFF >> len);
  endfunction

  function automatic void ref_lookup(input logic [31:0] a, output bit h, output logic [PW-1:0] p);
    int best;
    best = 0;
    h = 0;
    p = '0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_len[i] >= 1 && m_len[i] <= 32 &&
          ((a & ref_mask(int'(m_len[i]))) == (m_pfx[i] & ref_mask(int'(m_len[i])))) &&
          int'(m_len[i]) > best) begin
        best = int'(m_len[i]);
        h = 1;
        p = m_port[i];
      end
    end
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input int wi, input logic [31:0] wp, input int wl,
                      input int wport, input bit wv, input bit rv, input logic [31:0] ra,
                      input bit rr, input string tag);
    bit eh;
    logic [PW-1:0] ep;
    @(negedge clk);
    wr_en = we; wr_idx = IW'(wi); wr_prefix = wp; wr_len = 6'(wl);
    wr_port = PW'(wport); wr_valid = wv;
    req_valid = rv; req_addr = ra; res_ready = rr;
    #1;
    if (prev_stall) begin
      check("R6", "held valid", 32'(res_valid), 32'd1);
      check("R6", "held hit", 32'(res_hit), 32'(held_hit));
      check("R6", "held port", 32'(res_port), 32'(held_port));
    end
    prev_stall = res_valid && !res_ready;
    if (prev_stall) begin
      held_hit = res_hit;
      held_port = res_port;
      check("R6", "ready while stalled", 32'(req_ready), 32'd0);
    end
    if (res_valid && res_ready) begin
      if (qh.size() == 0) begin
        check("R6", "unexpected result", 32'd1, 32'd0);
      end else begin
        string t;
        int s;
        t = qt.pop_front();
        s = qs.pop_front();
        check(t, "hit", 32'(res_hit), 32'(qh.pop_front()));
        check(t, "port", 32'(res_port), 32'(qp.pop_front()));
        if (lat_mode) check("R5", "latency", 32'(cyc - s), 32'(LAT));
      end
    end
    if (req_valid && req_ready) begin
      ref_lookup(ra, eh, ep);
      qh.push_back(eh); qp.push_back(ep); qt.push_back(tag); qs.push_back(cyc);
    end
    if (we && wi < N) begin
      m_v[wi] = wv; m_pfx[wi] = wp; m_len[wi] = 6'(wl); m_port[wi] = PW'(wport);
    end
    cyc++;
  endtask

  task automatic wr(input int wi, input logic [31:0] wp, input int wl, input int wport, input bit wv);
    step(1, wi, wp, wl, wport, wv, 0, 32'h0, 1, "");
  endtask

  task automatic look(input logic [31:0] ra, input string tag);
    step(0, 0, 32'h0, 0, 0, 0, 1, ra, 1, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 32'h0, 0, 0, 0, 0, 32'h0, 1, "");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_pfx[i] = '0; m_len[i] = '0; m_port[i] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8", "res_valid after reset", 32'(res_valid), 32'd0);
    check("R8", "req_ready after reset", 32'(req_ready), 32'd1);
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R8");
    idle(LAT + 1);

    // directed table
    wr(0, {8'd128, 8'd9, 8'd0, 8'd0}, 16, 1, 1);
    wr(5, {8'd65, 24'd0}, 8, 3, 1);
    wr(3, 32'h0, 0, 7, 1);
    wr(1, {8'd128, 8'd9, 8'd16, 8'd0}, 21, 2, 1);
    wr(2, {8'd128, 8'd9, 8'd16, 8'd0}, 21, 5, 1);
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R2");
    look({8'd128, 8'd9, 8'd200, 8'd1}, "R1");
    look({8'd65, 8'd1, 8'd2, 8'd3}, "R1");
    look({8'd200, 8'd0, 8'd0, 8'd1}, "R4");
    step(1, 6, {8'd10, 24'd0}, 40, 4, 1, 1, {8'd10, 8'd1, 8'd2, 8'd3}, 1, "R1");
    look({8'd10, 8'd1, 8'd2, 8'd3}, "R1");
    wr(7, {8'd192, 8'd168, 16'd0}, 16, 9, 1);
    wr(4, {8'd192, 8'd168, 16'd0}, 16, 8, 1);
    look({8'd192, 8'd168, 8'd1, 8'd1}, "R3");
    // same-cycle write and lookup
    step(1, 4, {8'd128, 8'd9, 8'd16, 8'd14}, 32, 6, 1, 1, {8'd128, 8'd9, 8'd16, 8'd14}, 1, "R7");
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R7");
    wr(4, {8'd128, 8'd9, 8'd16, 8'd14}, 32, 6, 0);
    look({8'd128, 8'd9, 8'd16, 8'd14}, "R9");
    look({8'd192, 8'd168, 8'd1, 8'd1}, "R9");
    // directed stall with a request waiting
    for (int k = 0; k < 6; k++) step(0, 0, 32'h0, 0, 0, 0, 1, {8'd128, 8'd9, 8'(k), 8'd1}, (k > 4), "R6");
    idle(LAT + 2);

    // constrained random traffic
    for (int k = 0; k < 800; k++) begin
      logic [31:0] pa, ra;
      pa = {8'd10, 8'($urandom % 4), 8'($urandom % 4), 8'($urandom)};
      ra = {8'd10, 8'($urandom % 4), 8'($urandom % 4), 8'($urandom)};
      step(($urandom % 4) == 0, int'($urandom % N), pa, int'($urandom % 35),
           int'($urandom % 16), ($urandom % 4) != 0, ($urandom % 3) != 0, ra,
           ($urandom % 4) != 0, "R2");
    end
    for (int k = 0; k < 40 && qh.size() != 0; k++) idle(1);
    idle(2);

    // back-to-back throughput with fixed latency
    lat_mode = 1;
    for (int k = 0; k < 40; k++) begin
      step(0, 0, 32'h0, 0, 0, 0, 1, {8'd10, 8'($urandom % 4), 8'($urandom % 4), 8'($urandom)}, 1, "R5");
      check("R5", "ready at full rate", 32'(req_ready), 32'd1);
    end
    idle(LAT + 2);
    check("R6", "results outstanding", 32'(qh.size()), 32'd0);
    finish_run();
  end
endmodule